// File: doc/BRIEF.md
# Multi-Device Flash Address Decoder

This block sits inside the target side of a serial-bus flash device. Several identical flash parts can share one bus. Each part has a 4-bit identity fixed by strap pins. When the host presents a memory-cycle address, the decoder does three things:

- It decides whether this part is the one being addressed.
- It decides whether the cycle targets the storage array or the register space.
- It decides whether a write may proceed under the two active-low protect pins.

The decision is captured on the address-valid strobe. It then holds until the bus logic signals the end of the cycle. Strap, protect or address changes partway through a cycle therefore cannot disturb an access that is already under way.

The identity field sits in address bits [22:19]. The value expected there depends on where the part is mapped in the 4 GB space:

- Mapped from the top: the field must equal the inverted strap, and bits [31:24] must be all ones.
- Mapped from the bottom: the field must equal the strap with its lowest bit flipped.

Each part holds 512 KiB, so bits [18:0] form the byte offset. The 64 KiB boot block occupies the top of that range and has its own protect pin.

Top module: `flash_addr_decode`

## Requirements
- R1: With mapTop=1, the part is selected only when addr[22:19] equals the bitwise inverse of strapId and addr[31:24] equals FFh.
- R2: With mapTop=0, the part is selected only when addr[22:19] equals strapId with bit 0 inverted; addr[31:24] is not examined.
- R3: On a mismatch, selected, memSpace, writeOk and writeReject stay 0 and byteOffset stays 0 until the next address-valid strobe.
- R4: For a selected cycle, memSpace equals addr[23] (1 means storage array, 0 means register space) and byteOffset equals addr[18:0].
- R5: When addrValid is high at a clock edge, the outputs reflect that address after that edge. They then stay stable until cycleEnd, whatever the address, strap or protect pins do.
- R6: cycleEnd without addrValid clears every output at the next edge. If addrValid and cycleEnd are high together, the new capture wins. Reset (rstN low) clears every output.
- R7: A selected read gives writeOk=0 and writeReject=0, and its selection is unaffected by either protect pin.
- R8: A selected write to the register space (addr[23]=0) gives writeOk=1 regardless of chipWpN and bootWpN.
- R9: A selected array write with offset 70000h..7FFFFh gives writeOk=bootWpN. chipWpN has no effect there.
- R10: A selected array write with offset below 70000h gives writeOk=chipWpN. bootWpN has no effect there.
- R11: A selected array write that is blocked raises writeReject for exactly the one cycle after capture. Reads, mismatches and allowed writes give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrValid | input | 1 | Address of a new memory cycle is present |
| cycleEnd | input | 1 | Current bus cycle has finished |
| addr | input | 32 | Host memory address |
| isWrite | input | 1 | 1 for write cycle, 0 for read |
| strapId | input | 4 | Strapped device identity |
| mapTop | input | 1 | 1 when mapped from top of 4 GB space, 0 from bottom |
| chipWpN | input | 1 | Active-low protect for array outside the boot block |
| bootWpN | input | 1 | Active-low protect for the boot block |
| selected | output | 1 | This part owns the current cycle |
| memSpace | output | 1 | 1 array access, 0 register access |
| byteOffset | output | 19 | Byte offset inside the part |
| writeOk | output | 1 | Write to the decoded location is permitted |
| writeReject | output | 1 | One-cycle pulse for a blocked array write |

## Verification
The assertions assume that addrValid is a single-cycle strobe with a known address beside it. They also assume that cycleEnd comes from the bus logic only after a capture. The strap and mapping inputs may change at any time.

The bench keeps within these limits. It drives every input on the falling edge and pulses addrValid for exactly one cycle per access. It ends each cycle with a one-cycle cycleEnd, except in the scenario that deliberately raises both strobes together. It samples outputs only on falling edges, so each capture is seen one edge after its strobe.

// File: rtl/flash_addr_decode_pkg.sv
package flash_addr_decode_pkg;

  typedef struct packed {
    logic capture;
    logic clear;
  } dcStrobe_t;

  typedef struct packed {
    logic hit;
    logic blocked;
  } dcStatus_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LIVE = 2'd1,
    ST_SKIP = 2'd2
  } dcState_t;

  // Field value a part with this strap expects in the select bits.
  function automatic logic [3:0] expectedField(input logic [3:0] strap, input logic fromTop);
    return fromTop ? ~strap : {strap[3:1], ~strap[0]};
  endfunction

endpackage

// File: rtl/flash_addr_decode_dp.sv
module flash_addr_decode_dp
  import flash_addr_decode_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ID_W      = 4,
  parameter int OFF_W     = 19,
  parameter int BOOT_LSB  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dcStrobe_t         strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              isWrite,
  input  logic [ID_W-1:0]   strapId,
  input  logic              mapTop,
  input  logic              chipWpN,
  input  logic              bootWpN,
  output dcStatus_t         status,
  output logic              memSpace,
  output logic [OFF_W-1:0]  byteOffset,
  output logic              writeOk
);

  localparam int WIN_BIT  = OFF_W + ID_W;
  localparam int HI_W     = ADDR_W - WIN_BIT - 1;
  localparam int BOOT_W   = OFF_W - BOOT_LSB;

  logic [ID_W-1:0]  fieldVal;
  logic [ID_W-1:0]  wantVal;
  logic             upperOk;
  logic             isMem;
  logic             inBoot;
  logic             allow;
  logic             hitNow;

  assign fieldVal = addr[WIN_BIT-1:OFF_W];
  assign wantVal  = expectedField(strapId, mapTop);
  assign upperOk  = !mapTop || (addr[ADDR_W-1:WIN_BIT+1] == {HI_W{1'b1}});
  assign hitNow   = upperOk && (fieldVal == wantVal);
  assign isMem    = addr[WIN_BIT];
  assign inBoot   = addr[OFF_W-1:BOOT_LSB] == {BOOT_W{1'b1}};

  always_comb begin
    if (!isMem)      allow = 1'b1;
    else if (inBoot) allow = bootWpN;
    else             allow = chipWpN;
  end

  assign status.hit     = hitNow;
  assign status.blocked = hitNow && isWrite && !allow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memSpace   <= 1'b0;
      byteOffset <= '0;
      writeOk    <= 1'b0;
    end else if (strobe.capture) begin
      memSpace   <= hitNow && isMem;
      byteOffset <= hitNow ? addr[OFF_W-1:0] : '0;
      writeOk    <= hitNow && isWrite && allow;
    end else if (strobe.clear) begin
      memSpace   <= 1'b0;
      byteOffset <= '0;
      writeOk    <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_addr_decode_ctrl.sv
module flash_addr_decode_ctrl
  import flash_addr_decode_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      addrValid,
  input  logic      cycleEnd,
  input  dcStatus_t status,
  output dcStrobe_t strobe,
  output logic      selected,
  output logic      writeReject
);

  dcState_t stateQ;
  dcState_t stateD;

  assign strobe.capture = addrValid;
  assign strobe.clear   = cycleEnd && !addrValid;

  always_comb begin
    stateD = stateQ;
    if (strobe.capture)    stateD = status.hit ? ST_LIVE : ST_SKIP;
    else if (strobe.clear) stateD = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      writeReject <= 1'b0;
    end else begin
      stateQ      <= stateD;
      writeReject <= strobe.capture && status.blocked;
    end
  end

  assign selected = (stateQ == ST_LIVE);

endmodule

// File: rtl/flash_addr_decode.sv
module flash_addr_decode
  import flash_addr_decode_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ID_W     = 4,
  parameter int OFF_W    = 19,
  parameter int BOOT_LSB = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrValid,
  input  logic              cycleEnd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              isWrite,
  input  logic [ID_W-1:0]   strapId,
  input  logic              mapTop,
  input  logic              chipWpN,
  input  logic              bootWpN,
  output logic              selected,
  output logic              memSpace,
  output logic [OFF_W-1:0]  byteOffset,
  output logic              writeOk,
  output logic              writeReject
);

  dcStrobe_t strobe;
  dcStatus_t status;

  flash_addr_decode_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .addrValid   (addrValid),
    .cycleEnd    (cycleEnd),
    .status      (status),
    .strobe      (strobe),
    .selected    (selected),
    .writeReject (writeReject)
  );

  flash_addr_decode_dp #(
    .ADDR_W   (ADDR_W),
    .ID_W     (ID_W),
    .OFF_W    (OFF_W),
    .BOOT_LSB (BOOT_LSB)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .addr       (addr),
    .isWrite    (isWrite),
    .strapId    (strapId),
    .mapTop     (mapTop),
    .chipWpN    (chipWpN),
    .bootWpN    (bootWpN),
    .status     (status),
    .memSpace   (memSpace),
    .byteOffset (byteOffset),
    .writeOk    (writeOk)
  );

endmodule

// File: rtl/flash_addr_decode_chk.sv
module flash_addr_decode_chk (
  input logic        clk,
  input logic        rstN,
  input logic        addrValid,
  input logic        cycleEnd,
  input logic [31:0] addr,
  input logic        isWrite,
  input logic [3:0]  strapId,
  input logic        mapTop,
  input logic        selected,
  input logic        memSpace,
  input logic [18:0] byteOffset,
  input logic        writeOk,
  input logic        writeReject
);

  // R1: top mapping needs all-ones upper byte
  a_r1_top_upper: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && mapTop && addr[31:24] != 8'hFF |=> !selected);

  // R2: bottom mapping field match selects
  a_r2_bottom_match: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && !mapTop && addr[22:19] == {strapId[3:1], ~strapId[0]} |=> selected);

  // R3: an unselected cycle shows nothing
  a_r3_quiet_miss: assert property (@(posedge clk) disable iff (!rstN)
    !selected |-> !memSpace && byteOffset == 19'd0 && !writeOk && !writeReject);

  // R5: decision holds between strobes
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid && !cycleEnd |=> $stable(selected) && $stable(memSpace)
                                && $stable(byteOffset) && $stable(writeOk));

  // R6: cycle end clears
  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    cycleEnd && !addrValid |=> !selected && !writeOk && !memSpace);

  // R7: reads never permit or reject a write
  a_r7_read_no_write: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && !isWrite |=> !writeOk && !writeReject);

  // R11: reject pulse only on a selected, blocked array write
  a_r11_reject_ctx: assert property (@(posedge clk) disable iff (!rstN)
    writeReject |-> selected && memSpace && !writeOk);

  a_r11_reject_single: assert property (@(posedge clk) disable iff (!rstN)
    writeReject && !addrValid |=> !writeReject);

endmodule

bind flash_addr_decode flash_addr_decode_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .addrValid   (addrValid),
  .cycleEnd    (cycleEnd),
  .addr        (addr),
  .isWrite     (isWrite),
  .strapId     (strapId),
  .mapTop      (mapTop),
  .selected    (selected),
  .memSpace    (memSpace),
  .byteOffset  (byteOffset),
  .writeOk     (writeOk),
  .writeReject (writeReject)
);

// File: tb/sim_flash_addr_decode.sv
`timescale 1ns/1ps
module sim_flash_addr_decode;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrValid = 1'b0;
  logic        cycleEnd = 1'b0;
  logic [31:0] addr = '0;
  logic        isWrite = 1'b0;
  logic [3:0]  strapId = '0;
  logic        mapTop = 1'b1;
  logic        chipWpN = 1'b1;
  logic        bootWpN = 1'b1;
  logic        selected, memSpace, writeOk, writeReject;
  logic [18:0] byteOffset;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_addr_decode u0 (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .cycleEnd(cycleEnd),
    .addr(addr), .isWrite(isWrite), .strapId(strapId), .mapTop(mapTop),
    .chipWpN(chipWpN), .bootWpN(bootWpN), .selected(selected),
    .memSpace(memSpace), .byteOffset(byteOffset), .writeOk(writeOk),
    .writeReject(writeReject)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkOut(input string tag, input bit eSel, input bit eMem,
                          input logic [18:0] eOff, input bit eOk, input bit eRej);
    chk(selected == eSel, {tag, " selected"}, 32'(selected), 32'(eSel));
    chk(memSpace == eMem, {tag, " memSpace"}, 32'(memSpace), 32'(eMem));
    chk(byteOffset == eOff, {tag, " byteOffset"}, 32'(byteOffset), 32'(eOff));
    chk(writeOk == eOk, {tag, " writeOk"}, 32'(writeOk), 32'(eOk));
    chk(writeReject == eRej, {tag, " writeReject"}, 32'(writeReject), 32'(eRej));
  endtask

  // Present one address for a single cycle; outputs are sampled after capture.
  task automatic present(input logic [31:0] a, input bit wr);
    @(negedge clk);
    addr = a; isWrite = wr; addrValid = 1'b1;
    @(negedge clk);
    addrValid = 1'b0;
  endtask

  task automatic endCycle();
    @(negedge clk);
    cycleEnd = 1'b1;
    @(negedge clk);
    cycleEnd = 1'b0;
  endtask

  // Full cycle: capture, check, check pulse gone, end, check clear.
  task automatic runCycle(input string tag, input logic [31:0] a, input bit wr,
                          input bit eSel, input bit eOk, input bit eRej);
    logic        eMem;
    logic [18:0] eOff;
    eMem = eSel && a[23];
    eOff = eSel ? a[18:0] : 19'd0;
    present(a, wr);
    checkOut(tag, eSel, eMem, eOff, eOk, eRej);
    @(negedge clk);
    checkOut({tag, " next"}, eSel, eMem, eOff, eOk, 1'b0);
    endCycle();
    checkOut({tag, " R6 cleared"}, 1'b0, 1'b0, 19'd0, 1'b0, 1'b0);
  endtask

  task automatic testReset();
    checkOut("R6 reset", 1'b0, 1'b0, 19'd0, 1'b0, 1'b0);
  endtask

  task automatic testTopMap();
    mapTop = 1'b1; strapId = 4'b0000;
    runCycle("R1 top id0 mem R4", 32'hFFF8_1234, 1'b0, 1'b1, 1'b0, 1'b0);
    strapId = 4'b0101;
    runCycle("R1 top id5 reg R4", 32'hFF50_0ABC, 1'b0, 1'b1, 1'b0, 1'b0);
    runCycle("R1 top upper byte bad", 32'hFE50_0ABC, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testBottomMap();
    mapTop = 1'b0; strapId = 4'b0000;
    runCycle("R2 bottom id0", 32'h0088_0042, 1'b0, 1'b1, 1'b0, 1'b0);
    strapId = 4'b0011;
    runCycle("R2 bottom id3 upper ignored", 32'h1290_0007, 1'b0, 1'b1, 1'b0, 1'b0);
    mapTop = 1'b1;
  endtask

  task automatic testMismatch();
    mapTop = 1'b1; strapId = 4'b0000;
    chipWpN = 1'b0;
    runCycle("R3 mismatch write", 32'hFFF0_0010, 1'b1, 1'b0, 1'b0, 1'b0);
    chipWpN = 1'b1;
  endtask

  task automatic testRead();
    strapId = 4'b0000; chipWpN = 1'b0; bootWpN = 1'b0;
    runCycle("R7 read under protect", 32'hFFFF_0001, 1'b0, 1'b1, 1'b0, 1'b0);
    chipWpN = 1'b1; bootWpN = 1'b1;
  endtask

  task automatic testRegWrite();
    strapId = 4'b0000; chipWpN = 1'b0; bootWpN = 1'b0;
    runCycle("R8 reg write protected pins", 32'hFF78_0003, 1'b1, 1'b1, 1'b1, 1'b0);
    chipWpN = 1'b1; bootWpN = 1'b1;
  endtask

  task automatic testBoot();
    strapId = 4'b0000;
    chipWpN = 1'b0; bootWpN = 1'b1;
    runCycle("R9 boot allowed chip pin low", 32'hFFFF_0000, 1'b1, 1'b1, 1'b1, 1'b0);
    chipWpN = 1'b1; bootWpN = 1'b0;
    runCycle("R9 R11 boot blocked", 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b1);
    bootWpN = 1'b1;
  endtask

  task automatic testChip();
    strapId = 4'b0000;
    chipWpN = 1'b1; bootWpN = 1'b0;
    runCycle("R10 array allowed boot pin low", 32'hFFFE_FFFF, 1'b1, 1'b1, 1'b1, 1'b0);
    chipWpN = 1'b0; bootWpN = 1'b1;
    runCycle("R10 R11 array blocked", 32'hFFF8_0000, 1'b1, 1'b1, 1'b0, 1'b1);
    chipWpN = 1'b1;
  endtask

  task automatic testHold();
    strapId = 4'b0000; mapTop = 1'b1;
    present(32'hFFF8_4321, 1'b1);
    checkOut("R5 captured", 1'b1, 1'b1, 19'h04321, 1'b1, 1'b0);
    @(negedge clk);
    strapId = 4'b1111; chipWpN = 1'b0; bootWpN = 1'b0; mapTop = 1'b0;
    addr = 32'h0000_0000; isWrite = 1'b0;
    @(negedge clk);
    @(negedge clk);
    checkOut("R5 held", 1'b1, 1'b1, 19'h04321, 1'b1, 1'b0);
    endCycle();
    checkOut("R5 R6 end", 1'b0, 1'b0, 19'd0, 1'b0, 1'b0);
    strapId = 4'b0000; chipWpN = 1'b1; bootWpN = 1'b1; mapTop = 1'b1;
  endtask

  task automatic testPrecedence();
    strapId = 4'b0000; mapTop = 1'b1;
    present(32'hFFF8_0005, 1'b0);
    @(negedge clk);
    addr = 32'hFFF8_0077; isWrite = 1'b0; addrValid = 1'b1; cycleEnd = 1'b1;
    @(negedge clk);
    addrValid = 1'b0; cycleEnd = 1'b0;
    checkOut("R6 capture beats end", 1'b1, 1'b1, 19'h00077, 1'b0, 1'b0);
    endCycle();
    checkOut("R6 after precedence", 1'b0, 1'b0, 19'd0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTopMap();
    testBottomMap();
    testMismatch();
    testRead();
    testRegWrite();
    testBoot();
    testChip();
    testHold();
    testPrecedence();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule